// File: doc/BRIEF.md
# Interrupt-Triggered Single-Transfer Data Mover

This block moves one data item each time a peripheral raises a service request. Software first programs a small control byte, a 24-bit buffer pointer, a 16-bit I/O register pointer and a 16-bit transfer count. Each accepted request then causes one bus read followed by one bus write over a simple single-master bus with valid/ready handshakes. The control byte sets the direction and the width of the move (byte or 16-bit word).

After each move the block advances the pointers that are not held, and it decrements the count. It then emits one of two pulses. A per-request done pulse means the service continues. An end-of-service pulse means the count has run out, or that the peripheral asked to stop and stopping is enabled. After an end-of-service pulse the block accepts no requests until software writes a new non-zero count.

The buffer pointer advances only in its low 16 bits, so each buffer stays inside one 64 KB page. A request that arrives while a move is in flight is kept pending and is served once the block is idle.

Top module: `io_mover`

## Requirements
- R1: After reset the block issues no bus request and no done/end pulse, and it ignores service requests until a non-zero count is written at configuration select 3.
- R2: Control bit 1 is the direction. With 0, the read uses the I/O pointer (zero-extended to 24 bits) and the write uses the buffer pointer. With 1, the read uses the buffer pointer and the write uses the I/O pointer.
- R3: Control bit 3 is the width (0 byte, 1 word) and is driven on `busWord`. A byte move writes read bits 7:0 with the upper byte zero, and a word move writes all 16 bits. Unheld pointers step by 1 for a byte and by 2 for a word.
- R4: Control bit 4 held at 1 keeps the I/O pointer fixed. At 0 the pointer advances after every move.
- R5: Control bit 2 held at 1 keeps the buffer pointer fixed. At 0 only its low 16 bits advance, wrapping inside the page, and bits 23:16 never change except through a software write.
- R6: Each move decrements the count by one. When the count stays non-zero and no valid stop is pending, a single-cycle done pulse follows the move.
- R7: A move that takes the count from 1 to 0 produces an end pulse instead of a done pulse. Further requests are then ignored, with no bus activity.
- R8: `stopIn` given together with a request ends the service after that move when control bit 0 is 1. When bit 0 is 0 the stop has no effect, and a done pulse follows as normal.
- R9: A request that arrives while a move is in progress, including in the cycle of its completion, is held and served afterwards, and no request is lost.
- R10: While a bus phase waits for `busReady`, `busReq`, `busWe` and `busAddr` stay stable. The read always completes before the write starts.
- R11: Done and end are never high together, and each lasts exactly one cycle per move.
- R12: Configuration reads return the control byte with bits 7:5 as zero (select 0), the buffer pointer (select 1), the I/O pointer zero-extended (select 2) and the count (select 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 control, 1 buffer pointer, 2 I/O pointer, 3 count |
| cfgWdata | input | 24 | Configuration write data |
| cfgRdata | output | 24 | Configuration read data for `cfgSel` |
| reqIn | input | 1 | Peripheral service request, one cycle per request |
| stopIn | input | 1 | Stop indication, sampled with `reqIn` |
| busReq | output | 1 | Bus phase valid |
| busWe | output | 1 | Bus phase is a write |
| busWord | output | 1 | Bus phase is 16-bit (else byte) |
| busAddr | output | 24 | Bus address |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data, valid with `busReady` on a read |
| busReady | input | 1 | Bus phase accepted |
| doneOut | output | 1 | One-cycle pulse: move done, service continues |
| endOut | output | 1 | One-cycle pulse: service ended |

## Verification
Two pairs of events can share a cycle. The first pair is the pointer/count update of one move and the arrival of the next request. The bench raises a second request exactly in the update cycle, and also during the read phase, and then expects two completion pulses, two bus writes and a count lower by two. The second pair is the count running out and a valid peripheral stop. The bench sends a stop with the final request and expects exactly one end pulse, no done pulse, and no further service.

// File: rtl/io_mover_pkg.sv
package io_mover_pkg;
  localparam int CTRL_W    = 5;
  localparam int BIT_SE    = 0;
  localparam int BIT_DIR   = 1;
  localparam int BIT_BHOLD = 2;
  localparam int BIT_WORD  = 3;
  localparam int BIT_IHOLD = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_IO   = 2'd2,
    SEL_CNT  = 2'd3
  } cfgSelT;

  typedef struct packed {
    logic readPhase;
    logic writePhase;
    logic capture;
    logic update;
  } moverStrobeT;
endpackage

// File: rtl/mover_ctrl.sv
module mover_ctrl
  import io_mover_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic        armed,
  input  logic        busReady,
  output moverStrobeT strobe,
  output logic        busReq,
  output logic        busWe
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_UPDATE} stateT;

  stateT stateQ, stateD;
  logic  pendingQ, pendingD;
  logic  start;

  assign start = (stateQ == ST_IDLE) && pendingQ && armed;

  // Held request: set wins over the clear taken by a start.
  assign pendingD = (pendingQ && !start && armed) || (reqIn && armed);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    busReq = 1'b0;
    busWe  = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (start) stateD = ST_READ;
      ST_READ: begin
        busReq           = 1'b1;
        strobe.readPhase = 1'b1;
        if (busReady) begin
          strobe.capture = 1'b1;
          stateD         = ST_WRITE;
        end
      end
      ST_WRITE: begin
        busReq            = 1'b1;
        busWe             = 1'b1;
        strobe.writePhase = 1'b1;
        if (busReady) stateD = ST_UPDATE;
      end
      ST_UPDATE: begin
        strobe.update = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendingQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      pendingQ <= pendingD;
    end
  end

  // R9
  req_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn && armed) |=> (pendingQ || stateQ != ST_IDLE));
endmodule

// File: rtl/mover_dp.sv
module mover_dp
  import io_mover_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  moverStrobeT       strobe,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic              reqIn,
  input  logic              stopIn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWord,
  output logic              armed,
  output logic              doneOut,
  output logic              endOut
);
  localparam int ZEXT_W = ADDR_W - IO_W;
  localparam int BYTE_W = 8;

  logic [CTRL_W-1:0] ctrlQ;
  logic [ADDR_W-1:0] bufQ;
  logic [IO_W-1:0]   ioQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] dataQ;
  logic              armedQ, stopQ, doneQ, endQ;

  logic [ADDR_W-1:0] ioAddr, srcAddr, dstAddr;
  logic [PAGE_W-1:0] bufStep;
  logic [IO_W-1:0]   ioStep;
  logic              lastXfer;
  logic              wrCtrl, wrBuf, wrIo, wrCnt;

  assign wrCtrl = cfgWe && (cfgSel == SEL_CTRL);
  assign wrBuf  = cfgWe && (cfgSel == SEL_BUF);
  assign wrIo   = cfgWe && (cfgSel == SEL_IO);
  assign wrCnt  = cfgWe && (cfgSel == SEL_CNT);

  assign ioAddr  = {{ZEXT_W{1'b0}}, ioQ};
  assign srcAddr = ctrlQ[BIT_DIR] ? bufQ : ioAddr;
  assign dstAddr = ctrlQ[BIT_DIR] ? ioAddr : bufQ;
  assign busAddr = strobe.writePhase ? dstAddr : srcAddr;
  assign busWdata = dataQ;
  assign busWord  = ctrlQ[BIT_WORD];

  assign bufStep = ctrlQ[BIT_WORD] ? PAGE_W'(2) : PAGE_W'(1);
  assign ioStep  = ctrlQ[BIT_WORD] ? IO_W'(2)   : IO_W'(1);
  assign lastXfer = (cntQ == CNT_W'(1)) || (ctrlQ[BIT_SE] && stopQ);

  // Software-owned state: contents undefined until programmed.
  always_ff @(posedge clk) begin
    if (wrCtrl) ctrlQ <= cfgWdata[CTRL_W-1:0];

    if (wrBuf) bufQ <= cfgWdata;
    else if (strobe.update && !ctrlQ[BIT_BHOLD])
      bufQ[PAGE_W-1:0] <= bufQ[PAGE_W-1:0] + bufStep;

    if (wrIo) ioQ <= cfgWdata[IO_W-1:0];
    else if (strobe.update && !ctrlQ[BIT_IHOLD])
      ioQ <= ioQ + ioStep;

    if (strobe.capture)
      dataQ <= ctrlQ[BIT_WORD] ? busRdata
                               : {{(DATA_W-BYTE_W){1'b0}}, busRdata[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      armedQ <= 1'b0;
      stopQ  <= 1'b0;
      doneQ  <= 1'b0;
      endQ   <= 1'b0;
    end else begin
      doneQ <= strobe.update && !lastXfer;
      endQ  <= strobe.update && lastXfer;
      stopQ <= (stopQ && !strobe.update) || (reqIn && stopIn && armedQ);
      if (wrCnt) begin
        cntQ   <= cfgWdata[CNT_W-1:0];
        armedQ <= (cfgWdata[CNT_W-1:0] != '0);
      end else if (strobe.update) begin
        cntQ <= cntQ - CNT_W'(1);
        if (lastXfer) armedQ <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (cfgSel)
      SEL_CTRL: cfgRdata = ADDR_W'(ctrlQ);
      SEL_BUF:  cfgRdata = bufQ;
      SEL_IO:   cfgRdata = ioAddr;
      default:  cfgRdata = ADDR_W'(cntQ);
    endcase
  end

  assign armed   = armedQ;
  assign doneOut = doneQ;
  assign endOut  = endQ;

  // R5
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrBuf |=> $stable(bufQ[ADDR_W-1:PAGE_W]));
  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && endQ));
  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ || endQ) |=> !(doneQ || endQ));
endmodule

// File: rtl/io_mover.sv
module io_mover
  import io_mover_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic              reqIn,
  input  logic              stopIn,
  output logic              busReq,
  output logic              busWe,
  output logic              busWord,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              doneOut,
  output logic              endOut
);
  moverStrobeT strobe;
  logic        armed;

  mover_ctrl u_ctrl (
    .clk, .rstN, .reqIn, .armed, .busReady,
    .strobe, .busReq, .busWe
  );

  mover_dp #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk, .rstN, .strobe, .cfgWe, .cfgSel, .cfgWdata, .cfgRdata,
    .reqIn, .stopIn, .busRdata, .busAddr, .busWdata, .busWord,
    .armed, .doneOut, .endOut
  );

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busWe) && $stable(busAddr)));
endmodule

// File: tb/tb_io_mover.sv
module tb_io_mover;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [23:0] cfgWdata = '0;
  logic [23:0] cfgRdata;
  logic        reqIn = 1'b0, stopIn = 1'b0;
  logic        busReq, busWe, busWord, busReady;
  logic [23:0] busAddr;
  logic [15:0] busWdata, busRdata;
  logic        doneOut, endOut;
  logic        readyEn = 1'b1;

  int nChecks = 0, nFails = 0;
  int wrCnt = 0, doneCnt = 0, endCnt = 0;
  logic [23:0] lastRA, lastWA;
  logic [15:0] lastWD;
  logic        lastWW;

  always #10 clk = ~clk;

  assign busReady = readyEn && busReq;
  assign busRdata = busAddr[15:0] ^ 16'hA55A;

  io_mover dut (.*);

  always @(posedge clk) begin
    if (busReq && busReady && !busWe) lastRA <= busAddr;
    if (busReq && busReady && busWe) begin
      wrCnt  <= wrCnt + 1;
      lastWA <= busAddr;
      lastWD <= busWdata;
      lastWW <= busWord;
    end
    if (doneOut) doneCnt <= doneCnt + 1;
    if (endOut)  endCnt  <= endCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, output logic [23:0] d);
    @(negedge clk); cfgSel = sel; #1 d = cfgRdata;
  endtask

  task automatic pulseReq(input logic stop);
    @(negedge clk); reqIn = 1'b1; stopIn = stop;
    @(negedge clk); reqIn = 1'b0; stopIn = 1'b0;
  endtask

  task automatic waitPulses(input int n);
    int base = doneCnt + endCnt;
    for (int i = 0; i < 60 && (doneCnt + endCnt) < base + n; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [4:0] c, input logic [23:0] b, input logic [15:0] io, input logic [15:0] n);
    cfgWrite(2'd0, {19'd0, c});
    cfgWrite(2'd1, b);
    cfgWrite(2'd2, {8'd0, io});
    cfgWrite(2'd3, {8'd0, n});
  endtask

  task automatic t_reset();
    logic [23:0] r;
    int w0;
    chk(busReq == 1'b0, "R1 busReq after reset", busReq, 0);
    chk(!doneOut && !endOut, "R1 pulses after reset", {doneOut, endOut}, 0);
    w0 = wrCnt;
    pulseReq(1'b0);
    repeat (10) @(negedge clk);
    chk(wrCnt == w0, "R1 unarmed request ignored", wrCnt, w0);
    cfgWrite(2'd0, 24'hFFFFFF);
    cfgRead(2'd0, r);
    chk(r == 24'h00001F, "R12 control readback", r, 24'h1F);
  endtask

  task automatic t_dir0Byte();
    logic [23:0] r;
    int d0 = doneCnt, e0 = endCnt;
    setup(5'h00, 24'h12FFFF, 16'h0040, 16'd5);
    pulseReq(1'b0);
    waitPulses(1);
    chk(lastRA == 24'h000040, "R2 dir0 read addr", lastRA, 24'h40);
    chk(lastWA == 24'h12FFFF, "R2 dir0 write addr", lastWA, 24'h12FFFF);
    chk(lastWD == 16'h001A && !lastWW, "R3 byte data", {lastWW, lastWD}, 16'h001A);
    cfgRead(2'd2, r);
    chk(r == 24'h000041, "R4 io advance by 1", r, 24'h41);
    cfgRead(2'd1, r);
    chk(r == 24'h120000, "R5 page wrap", r, 24'h120000);
    cfgRead(2'd3, r);
    chk(r == 24'd4, "R6 count dec", r, 4);
    chk(doneCnt == d0 + 1 && endCnt == e0, "R6 R11 one done", doneCnt - d0, 1);
  endtask

  task automatic t_dir1WordHold();
    logic [23:0] r;
    setup(5'h1A, 24'h340100, 16'h0200, 16'd3);
    pulseReq(1'b0);
    waitPulses(1);
    chk(lastRA == 24'h340100, "R2 dir1 read addr", lastRA, 24'h340100);
    chk(lastWA == 24'h000200, "R2 dir1 write addr", lastWA, 24'h200);
    chk(lastWD == 16'hA45A && lastWW, "R3 word data", {lastWW, lastWD}, 20'h1A45A);
    cfgRead(2'd2, r);
    chk(r == 24'h000200, "R4 io held", r, 24'h200);
    cfgRead(2'd1, r);
    chk(r == 24'h340102, "R3 buf step 2", r, 24'h340102);
  endtask

  task automatic t_bufHold();
    logic [23:0] r;
    setup(5'h04, 24'h560080, 16'h0010, 16'd3);
    pulseReq(1'b0);
    waitPulses(1);
    chk(lastWA == 24'h560080 && lastWD == 16'h004A, "R5 held buf write", lastWD, 16'h4A);
    cfgRead(2'd1, r);
    chk(r == 24'h560080, "R5 buf held", r, 24'h560080);
    cfgRead(2'd2, r);
    chk(r == 24'h000011, "R4 io advances", r, 24'h11);
  endtask

  task automatic t_stop();
    logic [23:0] r;
    int d0, e0, w0;
    setup(5'h01, 24'h100000, 16'h0000, 16'd10);
    e0 = endCnt; d0 = doneCnt;
    pulseReq(1'b1);
    waitPulses(1);
    chk(endCnt == e0 + 1 && doneCnt == d0, "R8 stop ends", endCnt - e0, 1);
    cfgRead(2'd3, r);
    chk(r == 24'd9, "R8 count after stop", r, 9);
    w0 = wrCnt;
    pulseReq(1'b0);
    repeat (10) @(negedge clk);
    chk(wrCnt == w0, "R7 no service after end", wrCnt, w0);
    setup(5'h00, 24'h100000, 16'h0000, 16'd10);
    e0 = endCnt; d0 = doneCnt;
    pulseReq(1'b1);
    waitPulses(1);
    chk(doneCnt == d0 + 1 && endCnt == e0, "R8 stop ignored", doneCnt - d0, 1);
  endtask

  task automatic t_countEnd();
    logic [23:0] r;
    int d0, e0, w0;
    setup(5'h00, 24'h200000, 16'h0000, 16'd2);
    d0 = doneCnt; e0 = endCnt;
    pulseReq(1'b0); waitPulses(1);
    chk(doneCnt == d0 + 1, "R6 first done", doneCnt - d0, 1);
    pulseReq(1'b1); waitPulses(1);
    chk(endCnt == e0 + 1 && doneCnt == d0 + 1, "R7 end at zero", endCnt - e0, 1);
    w0 = wrCnt;
    pulseReq(1'b0);
    repeat (10) @(negedge clk);
    chk(wrCnt == w0, "R7 ignored after zero", wrCnt, w0);
    cfgRead(2'd3, r);
    chk(r == 24'd0, "R7 count zero", r, 0);
  endtask

  task automatic t_pending();
    logic [23:0] r;
    int w0, d0;
    setup(5'h00, 24'h300000, 16'h0000, 16'd5);
    w0 = wrCnt; d0 = doneCnt;
    pulseReq(1'b0);
    repeat (2) @(negedge clk);
    pulseReq(1'b0);
    waitPulses(2);
    chk(wrCnt == w0 + 2 && doneCnt == d0 + 2, "R9 request in update cycle", wrCnt - w0, 2);
    w0 = wrCnt;
    pulseReq(1'b0);
    pulseReq(1'b0);
    waitPulses(2);
    chk(wrCnt == w0 + 2, "R9 request during read", wrCnt - w0, 2);
    cfgRead(2'd3, r);
    chk(r == 24'd1, "R9 count after four", r, 1);
  endtask

  task automatic t_stall();
    logic [23:0] a0;
    setup(5'h00, 24'h400010, 16'h0080, 16'd5);
    readyEn = 1'b0;
    pulseReq(1'b0);
    repeat (2) @(negedge clk);
    a0 = busAddr;
    chk(busReq && !busWe && a0 == 24'h000080, "R10 read waits", a0, 24'h80);
    repeat (3) @(negedge clk);
    chk(busReq && !busWe && busAddr == a0, "R10 read held", busAddr, a0);
    readyEn = 1'b1;
    waitPulses(1);
    chk(lastWA == 24'h400010 && lastWD == 16'h00DA, "R10 stalled move", lastWD, 16'hDA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir0Byte();
    t_dir1WordHold();
    t_bufHold();
    t_stop();
    t_countEnd();
    t_pending();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule